// File: doc/BRIEF.md
# Calendar Time Event Detector

This block sits beside a running BCD clock-calendar. It reads the current second, minute, hour, AM/PM marker, weekday, day of month and month. It also takes a strobe that pulses for one cycle each time the clock advances by one second. From these it keeps four sticky flags.

The second flag is set on every advance. The time flag is set when a software-chosen time boundary is crossed: every new minute, every new hour, each midnight or each noon. The calendar flag is set when a chosen calendar boundary is reached: the start of a week, the start of a month or the start of a year. The error flag reports that the value on the inputs is not a legal time or date.

Each flag stays set until its own clear input is pulsed. The inputs carry a value that is refreshed at the strobe and have no back-pressure. The strobe is a plain one-cycle pulse, and the detector accepts every strobe, so no valid/ready handshake is used. The timekeeping counters and any register access sit outside the block.

Top module: `cal_time_event_det`

## Requirements
- R1: While reset is asserted, and after its release until an event occurs, all four flags read 0 (for a valid input value).
- R2: The second flag reads 1 in the cycle after every cycle in which the advance strobe is high.
- R3: With time select 0, the time flag is set after a strobe whose seconds field is 00 (a new minute).
- R4: With time select 1, the time flag is set after a strobe whose seconds and minutes are both 00. A strobe at xx:mm:00 with mm not 00 does not set it.
- R5: With time select 2 (midnight), the time flag is set after a strobe at 00:00:00. In 24-hour mode midnight is hour 00. In 12-hour mode it is hour 12 with the PM bit 0. Hour 12 with PM 1 does not match.
- R6: With time select 3 (noon), the time flag is set after a strobe at 12:00:00. In 24-hour mode this is hour 12. In 12-hour mode it is hour 12 with the PM bit 1. Hour 12 with PM 0 does not match.
- R7: With calendar select 0, the calendar flag is set after a strobe at midnight when the weekday field equals 1 (Monday). Other weekdays, or a non-zero seconds field, do not set it.
- R8: With calendar select 1, the calendar flag is set after a strobe at midnight when the day of month is 01.
- R9: With calendar select 2, the calendar flag is set after a strobe at midnight on day 01 of month 01. Day 01 of month 02 does not set it.
- R10: Input values that match a boundary set no event flag in cycles where the strobe is low.
- R11: Each event flag stays 1 until its clear is pulsed. A clear in a cycle with no new event makes the flag 0 in the next cycle. A clear in the same cycle as a new event leaves the flag 1.
- R12: The error flag is set in the cycle after any cycle in which the inputs are not valid, whether the strobe is high or not. The inputs are invalid when any digit exceeds 9, seconds or minutes exceed 59, or the hour exceeds 23 in 24-hour mode. They are also invalid when the hour is outside 1..12 in 12-hour mode, the day is 00 or above 31, or the month is 00 or above 12.
- R13: A clear of the error flag while the inputs are still invalid leaves it 1. Once the inputs are valid, a clear makes it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, clock advanced by one second |
| sec_i | input | 7 | Seconds, BCD |
| min_i | input | 7 | Minutes, BCD |
| hour_i | input | 6 | Hours, BCD |
| pm_i | input | 1 | PM marker (12-hour mode only) |
| wday_i | input | 3 | Weekday, 1 = Monday |
| mday_i | input | 6 | Day of month, BCD |
| month_i | input | 5 | Month, BCD |
| h12_i | input | 1 | 1 = 12-hour mode, 0 = 24-hour mode |
| tsel_i | input | 2 | Time boundary: 0 minute, 1 hour, 2 midnight, 3 noon |
| csel_i | input | 2 | Calendar boundary: 0 week, 1 month, 2 year, 3 none |
| clr_sec_i | input | 1 | Clear pulse, second flag |
| clr_tim_i | input | 1 | Clear pulse, time flag |
| clr_cal_i | input | 1 | Clear pulse, calendar flag |
| clr_err_i | input | 1 | Clear pulse, error flag |
| sec_flag_o | output | 1 | Sticky second flag |
| tim_flag_o | output | 1 | Sticky time-boundary flag |
| cal_flag_o | output | 1 | Sticky calendar-boundary flag |
| err_flag_o | output | 1 | Sticky invalid-value flag |

## Verification
Each boundary code is driven with an input value that matches it and with a near miss. The near misses include the wrong AM/PM half, a weekday other than Monday, day 02 and month 02, and a non-zero second or minute. These separate a correct decode from one that checks too few fields. Matching values held without a strobe show that events are gated by the strobe. A clear that coincides with an event separates set-priority from clear-priority. Invalid values are presented one field at a time: a non-BCD digit, hour 24, hour 00 in 12-hour mode, day 00 and month 13. Each one is cleared while still invalid and again after repair, so that the re-arm behaviour is exercised.

// File: rtl/cte_pkg.sv
package cte_pkg;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int MDAY_W = 6;
  localparam int MON_W  = 5;
  localparam int WDAY_W = 3;
  localparam int SEL_W  = 2;
  localparam int BCD2_W = 8;

  localparam int FLG_SEC = 0;
  localparam int FLG_TIM = 1;
  localparam int FLG_CAL = 2;
  localparam int FLG_ERR = 3;
  localparam int NUM_FLG = 4;

  typedef enum logic [SEL_W-1:0] {
    TB_MINUTE   = 2'd0,
    TB_HOUR     = 2'd1,
    TB_MIDNIGHT = 2'd2,
    TB_NOON     = 2'd3
  } tbound_e;

  typedef enum logic [SEL_W-1:0] {
    CB_WEEK  = 2'd0,
    CB_MONTH = 2'd1,
    CB_YEAR  = 2'd2,
    CB_NONE  = 2'd3
  } cbound_e;

  // Both nibbles of a two-digit BCD value are decimal digits.
  function automatic logic digits_ok(input logic [BCD2_W-1:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  // Two-digit BCD value within [lo, hi] (limits written as BCD).
  function automatic logic bcd_in_range(input logic [BCD2_W-1:0] v,
                                        input logic [BCD2_W-1:0] lo,
                                        input logic [BCD2_W-1:0] hi);
    return digits_ok(v) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/cte_valid_chk.sv
module cte_valid_chk
  import cte_pkg::*;
#(
  parameter logic [BCD2_W-1:0] MAX_SEC   = 8'h59,
  parameter logic [BCD2_W-1:0] MAX_H24   = 8'h23,
  parameter logic [BCD2_W-1:0] MAX_H12   = 8'h12,
  parameter logic [BCD2_W-1:0] MAX_MDAY  = 8'h31,
  parameter logic [BCD2_W-1:0] MAX_MONTH = 8'h12
) (
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic [MDAY_W-1:0] mday_i,
  input  logic [MON_W-1:0]  month_i,
  input  logic              h12_i,
  output logic              bad_o
);
  localparam int SEC_PAD  = BCD2_W - SEC_W;
  localparam int MIN_PAD  = BCD2_W - MIN_W;
  localparam int HOUR_PAD = BCD2_W - HOUR_W;
  localparam int MDAY_PAD = BCD2_W - MDAY_W;
  localparam int MON_PAD  = BCD2_W - MON_W;

  logic [BCD2_W-1:0] sec_x, min_x, hour_x, mday_x, mon_x;
  logic sec_ok, min_ok, hour_ok, mday_ok, mon_ok;

  assign sec_x  = {{SEC_PAD{1'b0}},  sec_i};
  assign min_x  = {{MIN_PAD{1'b0}},  min_i};
  assign hour_x = {{HOUR_PAD{1'b0}}, hour_i};
  assign mday_x = {{MDAY_PAD{1'b0}}, mday_i};
  assign mon_x  = {{MON_PAD{1'b0}},  month_i};

  always_comb begin
    sec_ok  = bcd_in_range(sec_x, 8'h00, MAX_SEC);
    min_ok  = bcd_in_range(min_x, 8'h00, MAX_SEC);
    hour_ok = h12_i ? bcd_in_range(hour_x, 8'h01, MAX_H12)
                    : bcd_in_range(hour_x, 8'h00, MAX_H24);
    mday_ok = bcd_in_range(mday_x, 8'h01, MAX_MDAY);
    mon_ok  = bcd_in_range(mon_x, 8'h01, MAX_MONTH);
    bad_o   = !(sec_ok && min_ok && hour_ok && mday_ok && mon_ok);
  end
endmodule

// File: rtl/cte_boundary.sv
module cte_boundary
  import cte_pkg::*;
#(
  parameter logic [WDAY_W-1:0] WEEK_START = 3'd1,
  parameter logic [HOUR_W-1:0] NOON_HOUR  = 6'h12
) (
  input  logic              tick_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic              pm_i,
  input  logic [WDAY_W-1:0] wday_i,
  input  logic [MDAY_W-1:0] mday_i,
  input  logic [MON_W-1:0]  month_i,
  input  logic              h12_i,
  input  logic [SEL_W-1:0]  tsel_i,
  input  logic [SEL_W-1:0]  csel_i,
  output logic              tim_hit_o,
  output logic              cal_hit_o
);
  localparam logic [MDAY_W-1:0] FIRST_DAY   = MDAY_W'(1);
  localparam logic [MON_W-1:0]  FIRST_MONTH = MON_W'(1);

  logic top_of_min, top_of_hour, at_midnight, at_noon;
  logic tim_match, cal_match;
  tbound_e tsel;
  cbound_e csel;

  assign tsel = tbound_e'(tsel_i);
  assign csel = cbound_e'(csel_i);

  always_comb begin
    top_of_min  = (sec_i == '0);
    top_of_hour = top_of_min && (min_i == '0);
    // In 12-hour mode both midnight and noon show hour 12; the half decides.
    if (h12_i) begin
      at_midnight = top_of_hour && (hour_i == NOON_HOUR) && !pm_i;
      at_noon     = top_of_hour && (hour_i == NOON_HOUR) &&  pm_i;
    end else begin
      at_midnight = top_of_hour && (hour_i == '0);
      at_noon     = top_of_hour && (hour_i == NOON_HOUR);
    end
  end

  always_comb begin
    unique case (tsel)
      TB_MINUTE:   tim_match = top_of_min;
      TB_HOUR:     tim_match = top_of_hour;
      TB_MIDNIGHT: tim_match = at_midnight;
      TB_NOON:     tim_match = at_noon;
      default:     tim_match = 1'b0;
    endcase
  end

  always_comb begin
    unique case (csel)
      CB_WEEK:  cal_match = at_midnight && (wday_i == WEEK_START);
      CB_MONTH: cal_match = at_midnight && (mday_i == FIRST_DAY);
      CB_YEAR:  cal_match = at_midnight && (mday_i == FIRST_DAY)
                            && (month_i == FIRST_MONTH);
      CB_NONE:  cal_match = 1'b0;
      default:  cal_match = 1'b0;
    endcase
  end

  assign tim_hit_o = tick_i && tim_match;
  assign cal_hit_o = tick_i && cal_match;
endmodule

// File: rtl/cte_sticky.sv
module cte_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    // Set wins over clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[g] <= 1'b0;
      else        flag_o[g] <= set_i[g] | (flag_o[g] & ~clr_i[g]);
    end
  end
endmodule

// File: rtl/cal_time_event_det.sv
module cal_time_event_det
  import cte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic              pm_i,
  input  logic [WDAY_W-1:0] wday_i,
  input  logic [MDAY_W-1:0] mday_i,
  input  logic [MON_W-1:0]  month_i,
  input  logic              h12_i,
  input  logic [SEL_W-1:0]  tsel_i,
  input  logic [SEL_W-1:0]  csel_i,
  input  logic              clr_sec_i,
  input  logic              clr_tim_i,
  input  logic              clr_cal_i,
  input  logic              clr_err_i,
  output logic              sec_flag_o,
  output logic              tim_flag_o,
  output logic              cal_flag_o,
  output logic              err_flag_o
);
  logic tim_hit, cal_hit, bad_val;
  logic [NUM_FLG-1:0] set_v, clr_v, flg_v;

  cte_boundary u_bound (
    .tick_i   (tick_i),
    .sec_i    (sec_i),
    .min_i    (min_i),
    .hour_i   (hour_i),
    .pm_i     (pm_i),
    .wday_i   (wday_i),
    .mday_i   (mday_i),
    .month_i  (month_i),
    .h12_i    (h12_i),
    .tsel_i   (tsel_i),
    .csel_i   (csel_i),
    .tim_hit_o(tim_hit),
    .cal_hit_o(cal_hit)
  );

  cte_valid_chk u_valid (
    .sec_i  (sec_i),
    .min_i  (min_i),
    .hour_i (hour_i),
    .mday_i (mday_i),
    .month_i(month_i),
    .h12_i  (h12_i),
    .bad_o  (bad_val)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[FLG_SEC] = tick_i;
    set_v[FLG_TIM] = tim_hit;
    set_v[FLG_CAL] = cal_hit;
    set_v[FLG_ERR] = bad_val;
    clr_v[FLG_SEC] = clr_sec_i;
    clr_v[FLG_TIM] = clr_tim_i;
    clr_v[FLG_CAL] = clr_cal_i;
    clr_v[FLG_ERR] = clr_err_i;
  end

  cte_sticky #(.N(NUM_FLG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .flag_o(flg_v)
  );

  assign sec_flag_o = flg_v[FLG_SEC];
  assign tim_flag_o = flg_v[FLG_TIM];
  assign cal_flag_o = flg_v[FLG_CAL];
  assign err_flag_o = flg_v[FLG_ERR];
endmodule

// File: rtl/cte_chk.sv
module cte_chk
  import cte_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic [SEC_W-1:0] sec_i,
  input logic [MIN_W-1:0] min_i,
  input logic             clr_sec_i,
  input logic             clr_tim_i,
  input logic             clr_err_i,
  input logic             sec_flag_o,
  input logic             tim_flag_o,
  input logic             cal_flag_o,
  input logic             err_flag_o
);
  // R2
  tick_sets_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> sec_flag_o);

  // R11
  sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sec_i && !tick_i) |=> !sec_flag_o);

  // R11
  tim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_flag_o && !clr_tim_i) |=> tim_flag_o);

  // R10
  tim_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tim_flag_o) |-> $past(tick_i && sec_i == '0));

  // R7
  cal_at_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_flag_o) |-> $past(tick_i && sec_i == '0 && min_i == '0));

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag_o && !clr_err_i) |=> err_flag_o);
endmodule

bind cal_time_event_det cte_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .sec_i     (sec_i),
  .min_i     (min_i),
  .clr_sec_i (clr_sec_i),
  .clr_tim_i (clr_tim_i),
  .clr_err_i (clr_err_i),
  .sec_flag_o(sec_flag_o),
  .tim_flag_o(tim_flag_o),
  .cal_flag_o(cal_flag_o),
  .err_flag_o(err_flag_o)
);

// File: tb/cal_time_event_det_tb.sv
`timescale 1ns/1ps
module cal_time_event_det_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [6:0] sec = 7'h15, mins = 7'h30;
  logic [5:0] hour = 6'h10;
  logic pm = 1'b0;
  logic [2:0] wday = 3'd3;
  logic [5:0] mday = 6'h15;
  logic [4:0] month = 5'h06;
  logic h12 = 1'b0;
  logic [1:0] tsel = 2'd0, csel = 2'd3;
  logic clr_sec = 1'b0, clr_tim = 1'b0, clr_cal = 1'b0, clr_err = 1'b0;
  logic sec_f, tim_f, cal_f, err_f;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cal_time_event_det u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .sec_i(sec), .min_i(mins), .hour_i(hour), .pm_i(pm),
    .wday_i(wday), .mday_i(mday), .month_i(month), .h12_i(h12),
    .tsel_i(tsel), .csel_i(csel),
    .clr_sec_i(clr_sec), .clr_tim_i(clr_tim), .clr_cal_i(clr_cal),
    .clr_err_i(clr_err),
    .sec_flag_o(sec_f), .tim_flag_o(tim_f), .cal_flag_o(cal_f),
    .err_flag_o(err_f)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic set_t(input logic m12, input logic [5:0] h, input logic p,
                       input logic [6:0] mi, input logic [6:0] s,
                       input logic [2:0] wd, input logic [5:0] md,
                       input logic [4:0] mo);
    @(negedge clk);
    h12 = m12; hour = h; pm = p; mins = mi; sec = s;
    wday = wd; mday = md; month = mo;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_sec = 1'b1; clr_tim = 1'b1; clr_cal = 1'b1; clr_err = 1'b1;
    @(negedge clk);
    clr_sec = 1'b0; clr_tim = 1'b0; clr_cal = 1'b0; clr_err = 1'b0;
  endtask

  // One time-boundary probe: set value, strobe, check, clear.
  task automatic probe_tim(input string req, input string what,
                           input logic m12, input logic [5:0] h,
                           input logic p, input logic [6:0] mi,
                           input logic [6:0] s, input logic exp);
    set_t(m12, h, p, mi, s, 3'd3, 6'h15, 5'h06);
    pulse_tick();
    chk(req, what, tim_f, exp);
    clear_all();
  endtask

  task automatic probe_cal(input string req, input string what,
                           input logic [6:0] s, input logic [2:0] wd,
                           input logic [5:0] md, input logic [4:0] mo,
                           input logic exp);
    set_t(1'b0, 6'h00, 1'b0, 7'h00, s, wd, md, mo);
    pulse_tick();
    chk(req, what, cal_f, exp);
    clear_all();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "sec in reset", sec_f, 1'b0);
    chk("R1", "err in reset", err_f, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "sec after reset", sec_f, 1'b0);
    chk("R1", "tim after reset", tim_f, 1'b0);
    chk("R1", "cal after reset", cal_f, 1'b0);
    chk("R1", "err after reset", err_f, 1'b0);
  endtask

  task automatic t_second();
    pulse_tick();
    chk("R2", "sec after tick", sec_f, 1'b1);
    repeat (3) @(negedge clk);
    chk("R11", "sec held", sec_f, 1'b1);
    @(negedge clk); clr_sec = 1'b1;
    @(negedge clk); clr_sec = 1'b0;
    chk("R11", "sec cleared", sec_f, 1'b0);
    pulse_tick();
    chk("R2", "sec second tick", sec_f, 1'b1);
    clear_all();
  endtask

  task automatic t_minute_hour();
    tsel = 2'd0;
    probe_tim("R3", "minute at :00", 1'b0, 6'h10, 1'b0, 7'h31, 7'h00, 1'b1);
    probe_tim("R3", "minute at :01", 1'b0, 6'h10, 1'b0, 7'h31, 7'h01, 1'b0);
    tsel = 2'd1;
    probe_tim("R4", "hour miss mm=31", 1'b0, 6'h10, 1'b0, 7'h31, 7'h00, 1'b0);
    probe_tim("R4", "hour at 11:00:00", 1'b0, 6'h11, 1'b0, 7'h00, 7'h00, 1'b1);
  endtask

  task automatic t_mid_noon();
    tsel = 2'd2;
    probe_tim("R5", "midnight 24h 00", 1'b0, 6'h00, 1'b0, 7'h00, 7'h00, 1'b1);
    probe_tim("R5", "midnight 24h 12", 1'b0, 6'h12, 1'b0, 7'h00, 7'h00, 1'b0);
    probe_tim("R5", "midnight 12h AM", 1'b1, 6'h12, 1'b0, 7'h00, 7'h00, 1'b1);
    probe_tim("R5", "midnight 12h PM", 1'b1, 6'h12, 1'b1, 7'h00, 7'h00, 1'b0);
    tsel = 2'd3;
    probe_tim("R6", "noon 24h 12", 1'b0, 6'h12, 1'b0, 7'h00, 7'h00, 1'b1);
    probe_tim("R6", "noon 24h 00", 1'b0, 6'h00, 1'b0, 7'h00, 7'h00, 1'b0);
    probe_tim("R6", "noon 12h PM", 1'b1, 6'h12, 1'b1, 7'h00, 7'h00, 1'b1);
    probe_tim("R6", "noon 12h AM", 1'b1, 6'h12, 1'b0, 7'h00, 7'h00, 1'b0);
  endtask

  task automatic t_calendar();
    csel = 2'd0;
    probe_cal("R7", "Monday midnight", 7'h00, 3'd1, 6'h15, 5'h06, 1'b1);
    probe_cal("R7", "Tuesday midnight", 7'h00, 3'd2, 6'h15, 5'h06, 1'b0);
    probe_cal("R7", "Monday 00:00:01", 7'h01, 3'd1, 6'h15, 5'h06, 1'b0);
    csel = 2'd1;
    probe_cal("R8", "day 01", 7'h00, 3'd4, 6'h01, 5'h06, 1'b1);
    probe_cal("R8", "day 02", 7'h00, 3'd4, 6'h02, 5'h06, 1'b0);
    csel = 2'd2;
    probe_cal("R9", "Jan 01", 7'h00, 3'd4, 6'h01, 5'h01, 1'b1);
    probe_cal("R9", "Feb 01", 7'h00, 3'd4, 6'h01, 5'h02, 1'b0);
  endtask

  task automatic t_no_tick();
    tsel = 2'd2; csel = 2'd0;
    set_t(1'b0, 6'h00, 1'b0, 7'h00, 7'h00, 3'd1, 6'h01, 5'h01);
    repeat (3) @(negedge clk);
    chk("R10", "tim without tick", tim_f, 1'b0);
    chk("R10", "cal without tick", cal_f, 1'b0);
    chk("R10", "sec without tick", sec_f, 1'b0);
    pulse_tick();
    chk("R10", "tim with tick", tim_f, 1'b1);
    chk("R10", "cal with tick", cal_f, 1'b1);
    // clear coinciding with a new event keeps the flag
    @(negedge clk); tick = 1'b1; clr_tim = 1'b1; clr_sec = 1'b1;
    @(negedge clk); tick = 1'b0; clr_tim = 1'b0; clr_sec = 1'b0;
    chk("R11", "tim clear+event", tim_f, 1'b1);
    chk("R11", "sec clear+event", sec_f, 1'b1);
    clear_all();
    chk("R11", "tim cleared", tim_f, 1'b0);
  endtask

  task automatic err_case(input string what, input logic m12,
                          input logic [5:0] h, input logic [6:0] s,
                          input logic [5:0] md, input logic [4:0] mo);
    set_t(m12, h, 1'b0, 7'h20, s, 3'd3, md, mo);
    @(negedge clk);
    chk("R12", what, err_f, 1'b1);
    clear_all();
    chk("R13", {what, " clear while bad"}, err_f, 1'b1);
    set_t(1'b0, 6'h10, 1'b0, 7'h20, 7'h10, 3'd3, 6'h15, 5'h06);
    clear_all();
    chk("R13", {what, " clear after fix"}, err_f, 1'b0);
  endtask

  task automatic t_error();
    set_t(1'b0, 6'h10, 1'b0, 7'h20, 7'h10, 3'd3, 6'h15, 5'h06);
    clear_all();
    chk("R12", "valid value", err_f, 1'b0);
    err_case("non-BCD seconds", 1'b0, 6'h10, 7'h5A, 6'h15, 5'h06);
    err_case("seconds 60", 1'b0, 6'h10, 7'h60, 6'h15, 5'h06);
    err_case("hour 24", 1'b0, 6'h24, 7'h10, 6'h15, 5'h06);
    err_case("12h hour 00", 1'b1, 6'h00, 7'h10, 6'h15, 5'h06);
    err_case("day 00", 1'b0, 6'h10, 7'h10, 6'h00, 5'h06);
    err_case("day 32", 1'b0, 6'h10, 7'h10, 6'h32, 5'h06);
    err_case("month 13", 1'b0, 6'h10, 7'h10, 6'h15, 5'h13);
    err_case("month 00", 1'b0, 6'h10, 7'h10, 6'h15, 5'h00);
  endtask

  initial begin
    t_reset();
    t_second();
    t_minute_hour();
    t_mid_noon();
    t_calendar();
    t_no_tick();
    t_error();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule